// File: doc/BRIEF.md
# Periodic Interrupt Rate Divider

This block turns a 32768 Hz tick enable into a programmable periodic event. A free-running prescaler advances once per accepted tick. A four-bit rate code picks a power-of-two period, and a one-cycle pulse is raised whenever the prescaler crosses a multiple of that period. The register block next to it latches the pulse into its status register (interrupt flag and periodic flag together) and drives the interrupt request. That register block is not part of this design.

Rate codes 3 to 15 give a period of 2^(code-1) ticks, from 4 ticks (8192 Hz) up to 16384 ticks (2 Hz). Codes 1 and 2 alias to codes 8 and 9. Code 0 stops the generator, and so does a low enable. The prescaler keeps counting while the generator is stopped. Because of this, every pulse lands on a period boundary of the count since reset, and never a fixed time after the last configuration change.

Top module: `periodic_irq_div`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `periodic_pulse` is 0. The prescaler restarts from zero, so with a code already set, the first pulse follows the tick whose count since reset equals one period.
- R2: `periodic_pulse` is high only in the cycle right after a clock edge at which `tick_en` was 1. It is never high for two cycles in a row.
- R3: For rate codes 3 to 15, consecutive pulses are exactly 2^(code-1) accepted ticks apart.
- R4: Rate code 1 gives a period of 128 ticks and rate code 2 gives a period of 256 ticks.
- R5: With rate code 0, no pulse is produced, whatever the value of `pie`.
- R6: With `pie` at 0, no pulse is produced for any rate code.
- R7: A pulse follows tick number N (counted since reset) exactly when N is a multiple of the selected period. The count advances while the generator is disabled, so after re-enabling, the first pulse comes at the next boundary and not one full period later.
- R8: `rate_code` and `pie` are sampled at the same edge as the tick they apply to. Clearing `pie` on a boundary tick suppresses that pulse. A code change on a tick is judged against the new period.
- R9: The prescaler advances only on edges where `tick_en` is 1, so the pulse spacing in clock cycles scales with the gap between ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | One-cycle enable at the 32768 Hz rate |
| rate_code | input | 4 | Rate select code (0 = off, 1 and 2 alias to 8 and 9) |
| pie | input | 1 | Periodic event enable |
| periodic_pulse | output | 1 | One-cycle pulse at each period boundary |

## Verification
Two events can fall in the same cycle: a boundary tick and a configuration change that lands on that tick. The bench waits until the tick about to be accepted is a boundary. It then either drops `pie`, or swaps the code, choosing a new code whose boundary does or does not match that tick. The pulse in the following cycle is checked against the period that the new configuration selects. A cycle-by-cycle reference model also runs in parallel. It counts accepted ticks from reset and flags every cycle where the pulse differs from the boundary rule.

// File: rtl/pid_pkg.sv
package pid_pkg;
    localparam int CODE_W = 4;

    // Codes 1 and 2 fold onto codes 8 and 9; every other code passes through.
    function automatic logic [CODE_W-1:0] fold_code(input logic [CODE_W-1:0] c);
        return (c != '0 && c <= 4'd2) ? c + 4'd7 : c;
    endfunction
endpackage

// File: rtl/pid_rate_decode.sv
module pid_rate_decode
    import pid_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic [CODE_W-1:0] rate_code,
    input  logic              pie,
    output logic              active_o,
    output logic [CNT_W-1:0]  mask_o
);
    logic [CODE_W-1:0] eff_code;
    logic [CODE_W-1:0] shamt;

    always_comb begin
        eff_code = fold_code(rate_code);
        shamt    = eff_code - 4'd1;
        active_o = pie && (rate_code != '0);
    end

    // Low 'shamt' bits of the mask are set: mask = period - 1.
    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
        assign mask_o[i] = (32'(shamt) > i);
    end
endmodule

// File: rtl/pid_prescaler.sv
module pid_prescaler #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_inc_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        cnt_inc_o = st_q.cnt + 1'b1;
        if (tick_en) begin
            st_d.cnt = cnt_inc_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/pid_boundary.sv
module pid_boundary #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             active,
    input  logic [CNT_W-1:0] mask,
    input  logic [CNT_W-1:0] cnt_inc,
    output logic             pulse_o
);
    typedef struct packed {
        logic pulse;
    } bnd_state_t;

    bnd_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = tick_en && active && ((cnt_inc & mask) == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;
endmodule

// File: rtl/periodic_irq_div.sv
module periodic_irq_div
    import pid_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [CODE_W-1:0] rate_code,
    input  logic              pie,
    output logic              periodic_pulse
);
    logic             active_w;
    logic [CNT_W-1:0] mask_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] cnt_inc_w;

    pid_rate_decode #(.CNT_W(CNT_W)) u_dec (
        .rate_code (rate_code),
        .pie       (pie),
        .active_o  (active_w),
        .mask_o    (mask_w)
    );

    pid_prescaler #(.CNT_W(CNT_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .cnt_o     (cnt_w),
        .cnt_inc_o (cnt_inc_w)
    );

    pid_boundary #(.CNT_W(CNT_W)) u_bnd (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .active  (active_w),
        .mask    (mask_w),
        .cnt_inc (cnt_inc_w),
        .pulse_o (periodic_pulse)
    );
endmodule

// File: rtl/periodic_irq_div_chk.sv
module periodic_irq_div_chk #(
    parameter int CNT_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic [3:0]       rate_code,
    input logic             pie,
    input logic             periodic_pulse,
    input logic [CNT_W-1:0] cnt
);
    AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        periodic_pulse |-> $past(tick_en)); // R2
    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        periodic_pulse |=> !periodic_pulse); // R2
    AST_NO_PULSE_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        periodic_pulse |-> ($past(rate_code) != 4'd0)); // R5
    AST_NO_PULSE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        periodic_pulse |-> $past(pie)); // R6
    AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt)); // R9
    AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> (cnt == $past(cnt) + 1'b1)); // R7
endmodule

bind periodic_irq_div periodic_irq_div_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick_en        (tick_en),
    .rate_code      (rate_code),
    .pie            (pie),
    .periodic_pulse (periodic_pulse),
    .cnt            (cnt_w)
);

// File: tb/periodic_irq_div_tb.sv
module periodic_irq_div_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [3:0] rate_code = 4'd0;
    logic       pie = 1'b0;
    logic       periodic_pulse;

    int checks = 0;
    int fails = 0;
    int ticks_issued = 0;
    int tick_gap = 0;
    int gap_ctr = 0;
    bit tick_on = 1'b0;
    bit done = 1'b0;

    // {code, tick gap, expected period in ticks}
    localparam int VEC [15][3] = '{
        '{1, 1, 128}, '{2, 1, 256}, '{3, 1, 4}, '{4, 1, 8}, '{5, 1, 16},
        '{6, 0, 32}, '{7, 0, 64}, '{8, 0, 128}, '{9, 0, 256}, '{10, 0, 512},
        '{11, 0, 1024}, '{12, 0, 2048}, '{13, 0, 4096}, '{14, 0, 8192}, '{15, 0, 16384}
    };

    periodic_irq_div u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_en        (tick_en),
        .rate_code      (rate_code),
        .pie            (pie),
        .periodic_pulse (periodic_pulse)
    );

    always #2 clk = ~clk;

    function automatic int period_of(input int code);
        int c;
        if (code == 0) return 0;
        c = (code <= 2) ? code + 7 : code;
        return 1 << (c - 1);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    endtask

    // Tick driver: drives tick_en on falling edges, counts ticks to be accepted.
    initial begin
        forever begin
            @(negedge clk);
            if (tick_on && gap_ctr >= tick_gap) begin
                tick_en = 1'b1;
                gap_ctr = 0;
                ticks_issued++;
            end else begin
                tick_en = 1'b0;
                if (tick_on) gap_ctr++;
            end
        end
    end

    // Reference model (R7): pulse iff accepted tick count is a period multiple.
    always @(posedge clk) begin
        #1;
        begin
            int p;
            bit exp_p;
            p = period_of(int'(rate_code));
            exp_p = rst_n && tick_en && pie && (p != 0) && (ticks_issued % (p == 0 ? 1 : p) == 0);
            if (exp_p || periodic_pulse)
                check(exp_p == periodic_pulse, "R7 model", int'(periodic_pulse), int'(exp_p));
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    task automatic step();
        @(posedge clk);
        #3;
    endtask

    task automatic sample_next(output logic v);
        @(posedge clk);
        #1;
        v = periodic_pulse;
        #2;
    endtask

    task automatic wait_pulse(input int lim, output int t, output int cyc);
        t = -1;
        cyc = 0;
        while (t < 0 && cyc < lim) begin
            @(posedge clk);
            #1;
            cyc++;
            if (periodic_pulse) t = ticks_issued;
            #2;
        end
    endtask

    task automatic count_pulses(input int n, output int cnt);
        logic v;
        cnt = 0;
        for (int k = 0; k < n; k++) begin
            sample_next(v);
            if (v) cnt++;
        end
    endtask

    initial begin
        int t1, t2, c1, c2, n, ten;
        logic v;
        @(posedge clk);
        #3;
        // R1: reset state
        check(periodic_pulse == 1'b0, "R1 in reset", int'(periodic_pulse), 0);
        repeat (3) step();
        rst_n = 1'b1;
        sample_next(v);
        check(v == 1'b0, "R1 after release", int'(v), 0);

        // R1: first pulse one period after reset
        rate_code = 4'd3; pie = 1'b1; tick_gap = 0; tick_on = 1'b1;
        wait_pulse(50, t1, c1);
        check(t1 == 4, "R1 first pulse tick", t1, 4);

        // Vector walk over every nonzero code: R3, R4, R7
        for (int i = 0; i < 15; i++) begin
            int per, lim;
            rate_code = 4'(VEC[i][0]);
            tick_gap = VEC[i][1];
            per = VEC[i][2];
            lim = (2 * per + 4) * (VEC[i][1] + 1) + 8;
            wait_pulse(lim, t1, c1);
            check(t1 >= 0 && t1 % per == 0, "R7 boundary", t1, per);
            wait_pulse(lim, t2, c2);
            if (VEC[i][0] <= 2)
                check(t2 - t1 == per, "R4 alias spacing", t2 - t1, per);
            else
                check(t2 - t1 == per, "R3 spacing", t2 - t1, per);
        end

        // R5: code 0 with enable high
        tick_gap = 0; rate_code = 4'd0; pie = 1'b1;
        count_pulses(600, n);
        check(n == 0, "R5 code zero", n, 0);

        // R6: enable low
        rate_code = 4'd3; pie = 1'b0;
        count_pulses(100, n);
        check(n == 0, "R6 enable low", n, 0);

        // R7: re-enable lands on next boundary, count kept running
        rate_code = 4'd6; pie = 1'b0;
        while (ticks_issued % 32 != 10) step();
        ten = ticks_issued;
        pie = 1'b1;
        wait_pulse(200, t1, c1);
        check(t1 % 32 == 0, "R7 realign", t1 % 32, 0);
        check(t1 - ten <= 32 && t1 - ten > 0, "R7 not full period", t1 - ten, 22);

        // R8: disable on the boundary tick suppresses it
        rate_code = 4'd3; pie = 1'b1; tick_gap = 0;
        step();
        while (!(tick_en && ticks_issued % 4 == 0)) step();
        pie = 1'b0;
        sample_next(v);
        check(v == 1'b0, "R8 disable on boundary", int'(v), 0);

        // R8: code change on a tick that is a boundary only for the old code
        pie = 1'b1;
        while (!(tick_en && ticks_issued % 16 == 4)) step();
        rate_code = 4'd5;
        sample_next(v);
        check(v == 1'b0, "R8 new code no boundary", int'(v), 0);

        // R8: code change on a tick that is a boundary only for the new code
        rate_code = 4'd7;
        step();
        while (!(tick_en && ticks_issued % 16 == 0 && ticks_issued % 64 != 0)) step();
        rate_code = 4'd5;
        sample_next(v);
        check(v == 1'b1, "R8 new code boundary", int'(v), 1);

        // R2: pulse is a single cycle
        sample_next(v);
        check(v == 1'b0, "R2 single cycle", int'(v), 0);

        // R9: ticks every fourth cycle, period 4 ticks = 16 cycles
        rate_code = 4'd3; tick_gap = 3;
        wait_pulse(200, t1, c1);
        wait_pulse(200, t2, c2);
        check(c2 == 16, "R9 cycle spacing", c2, 16);
        check(t2 - t1 == 4, "R9 tick spacing", t2 - t1, 4);

        // R1: reset in mid-run restarts the prescaler
        tick_gap = 0;
        @(posedge clk);
        #3;
        rst_n = 1'b0; tick_on = 1'b0; ticks_issued = 0; gap_ctr = 0;
        sample_next(v);
        check(v == 1'b0, "R1 mid-run reset", int'(v), 0);
        repeat (2) step();
        rst_n = 1'b1;
        rate_code = 4'd4;
        step();
        tick_on = 1'b1;
        wait_pulse(100, t1, c1);
        check(t1 == 8, "R1 restart first pulse", t1, 8);

        repeat (4) step();
        finish_run();
    end
endmodule